// File: doc/BRIEF.md
# APB4 Address-Decoding Bus Splitter

The splitter sits between one upstream APB4 requester and a set of downstream APB4 completers. It decodes the upstream address during the setup phase and raises the select of the one child whose window holds that address. It also rebases the address into that child's own local space. The enable, protection, write data and byte strobes go to every child unchanged. The ready, error and read data of the selected child go back upstream.

The address map has two fixed windows and a replicated array of identical children. Each array child sits at the array base plus its index times the array stride. An address that falls in no window never reaches a child. The splitter answers it itself at once with ready and an error, so an unmapped access cannot stall the bus.

A small phase tracker follows the upstream transfer. It has three states. PH_IDLE means no transfer is in its access phase. The move PH_IDLE to PH_ACCESS happens at the edge that ends a setup cycle (select high, enable low). PH_ACCESS is the first access cycle. It returns to PH_IDLE when ready is seen, or moves to PH_WAIT when ready is low. PH_WAIT holds an extended access phase and leaves for PH_IDLE on ready.

Top module: `apb_split`

## Requirements
- R1: While upstream select is high, the child select of the child whose window holds the address is the only child select that is high. The default map is: child 0 at 0x0000, 4 KiB; child 1 at 0x1000, 1 KiB; children 2..5 form the array, with base 0x2000, stride 0x100 and 0x100 bytes each.
- R2: A child's write strobe is high only when that child is selected and the upstream transfer is a write. Every other child sees it low.
- R3: A fixed child receives the upstream address minus its window base, truncated to log2 of its window size. Higher bits are zero.
- R4: Array child k receives the upstream address minus the array base minus k times the stride, truncated to log2 of the child size, so it lies in 0x00..0xFF.
- R5: Enable, protection, write data and byte strobes reach every child unchanged.
- R6: For a selected child, upstream ready, error and read data equal that child's ready, error and read data.
- R7: An upstream address in no window drives no child select and answers in the first access cycle with ready 1, error 1 and read data 0, for reads and writes alike.
- R8: While upstream select is low, all child selects are low and upstream ready, error and read data are 0.
- R9: The transfer stretches by exactly as many cycles as the selected child holds ready low, and the child selection holds through those wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the phase tracker |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable |
| s_pwrite | input | 1 | Upstream write/read |
| s_paddr | input | ADDR_W | Upstream address |
| s_pprot | input | 3 | Upstream protection |
| s_pwdata | input | DATA_W | Upstream write data |
| s_pstrb | input | DATA_W/8 | Upstream byte strobes |
| s_pready | output | 1 | Upstream ready |
| s_prdata | output | DATA_W | Upstream read data |
| s_pslverr | output | 1 | Upstream error |
| m_psel | output | NCH | Per-child select |
| m_penable | output | 1 | Enable to all children |
| m_pwrite | output | NCH | Per-child write strobe |
| m_paddr | output | NCH x ADDR_W | Per-child rebased address |
| m_pprot | output | 3 | Protection to all children |
| m_pwdata | output | DATA_W | Write data to all children |
| m_pstrb | output | DATA_W/8 | Byte strobes to all children |
| m_pready | input | NCH | Per-child ready |
| m_prdata | input | NCH x DATA_W | Per-child read data |
| m_pslverr | input | NCH | Per-child error |

## Verification
Some properties are checked on every cycle: at most one child select, write strobes only under a select, array addresses inside the child span, a quiet bus while idle, the immediate error response to a miss during an access, ready routed from the selected child, and a selection held through wait states. Other behaviour shows only in the bench's scenarios. These cover the exact rebased address for each window edge, read data and error routed from the right child, broadcast fields, and wait counts that match each behavioural child's random delay.

// File: rtl/apb_split_pkg.sv
package apb_split_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_WAIT   = 2'd2
    } apb_phase_e;

    typedef struct packed {
        logic ready;
        logic err;
    } split_resp_t;

endpackage

// File: rtl/apb_split_decode.sv
module apb_split_decode #(
    parameter int ADDR_W     = 16,
    parameter int R0_BASE    = 'h0000,
    parameter int R0_LOG2    = 12,
    parameter int R1_BASE    = 'h1000,
    parameter int R1_LOG2    = 10,
    parameter int ARR_BASE   = 'h2000,
    parameter int ARR_N      = 4,
    parameter int ARR_STRIDE = 'h100,
    parameter int ARR_LOG2   = 8,
    localparam int NCH       = 2 + ARR_N
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic [NCH-1:0]              hit,
    output logic [NCH-1:0][ADDR_W-1:0]  laddr
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int LG = (i == 0) ? R0_LOG2 : (i == 1) ? R1_LOG2 : ARR_LOG2;
        localparam logic [ADDR_W-1:0] BASE =
            (i == 0) ? ADDR_W'(R0_BASE) :
            (i == 1) ? ADDR_W'(R1_BASE) :
                       ADDR_W'(ARR_BASE + (i - 2) * ARR_STRIDE);
        localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << LG) - 64'd1);

        assign hit[i]   = ((addr ^ BASE) & ~MASK) == '0;
        assign laddr[i] = (addr - BASE) & MASK;
    end

endmodule

// File: rtl/apb_split_phase.sv
module apb_split_phase
    import apb_split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pready,
    output logic in_access,
    output logic in_wait
);

    apb_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_ACCESS;
            PH_ACCESS: state_d = pready ? PH_IDLE : PH_WAIT;
            PH_WAIT:   if (pready) state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        in_access = (state_q == PH_ACCESS) || (state_q == PH_WAIT);
        in_wait   = (state_q == PH_WAIT);
    end

endmodule

// File: rtl/apb_split_resp.sv
module apb_split_resp
    import apb_split_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = 6
) (
    input  logic [NCH-1:0]             sel,
    input  logic                       miss,
    input  logic [NCH-1:0]             c_ready,
    input  logic [NCH-1:0]             c_err,
    input  logic [NCH-1:0][DATA_W-1:0] c_rdata,
    output logic                       ready,
    output logic                       err,
    output logic [DATA_W-1:0]          rdata
);

    split_resp_t resp;

    always_comb begin
        resp  = '0;
        rdata = '0;
        if (miss) begin
            resp.ready = 1'b1;
            resp.err   = 1'b1;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (sel[i]) begin
                    resp.ready = c_ready[i];
                    resp.err   = c_err[i];
                    rdata      = c_rdata[i];
                end
            end
        end
        ready = resp.ready;
        err   = resp.err;
    end

endmodule

// File: rtl/apb_split.sv
module apb_split #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int R0_BASE    = 'h0000,
    parameter int R0_LOG2    = 12,
    parameter int R1_BASE    = 'h1000,
    parameter int R1_LOG2    = 10,
    parameter int ARR_BASE   = 'h2000,
    parameter int ARR_N      = 4,
    parameter int ARR_STRIDE = 'h100,
    parameter int ARR_LOG2   = 8,
    localparam int NCH       = 2 + ARR_N,
    localparam int STRB_W    = DATA_W / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_psel,
    input  logic                       s_penable,
    input  logic                       s_pwrite,
    input  logic [ADDR_W-1:0]          s_paddr,
    input  logic [2:0]                 s_pprot,
    input  logic [DATA_W-1:0]          s_pwdata,
    input  logic [STRB_W-1:0]          s_pstrb,
    output logic                       s_pready,
    output logic [DATA_W-1:0]          s_prdata,
    output logic                       s_pslverr,
    output logic [NCH-1:0]             m_psel,
    output logic                       m_penable,
    output logic [NCH-1:0]             m_pwrite,
    output logic [NCH-1:0][ADDR_W-1:0] m_paddr,
    output logic [2:0]                 m_pprot,
    output logic [DATA_W-1:0]          m_pwdata,
    output logic [STRB_W-1:0]          m_pstrb,
    input  logic [NCH-1:0]             m_pready,
    input  logic [NCH-1:0][DATA_W-1:0] m_prdata,
    input  logic [NCH-1:0]             m_pslverr
);

    logic [NCH-1:0] hit;
    logic [NCH-1:0] wr_sel;
    logic [NCH-1:0] rd_sel;
    logic           miss;
    logic           in_access;
    logic           in_wait;

    apb_split_decode #(
        .ADDR_W(ADDR_W), .R0_BASE(R0_BASE), .R0_LOG2(R0_LOG2),
        .R1_BASE(R1_BASE), .R1_LOG2(R1_LOG2), .ARR_BASE(ARR_BASE),
        .ARR_N(ARR_N), .ARR_STRIDE(ARR_STRIDE), .ARR_LOG2(ARR_LOG2)
    ) u_decode (
        .addr  (s_paddr),
        .hit   (hit),
        .laddr (m_paddr)
    );

    assign wr_sel    = hit & {NCH{s_psel &  s_pwrite}};
    assign rd_sel    = hit & {NCH{s_psel & ~s_pwrite}};
    assign miss      = s_psel & ~(|hit);
    assign m_psel    = wr_sel | rd_sel;
    assign m_pwrite  = wr_sel;
    assign m_penable = s_penable;
    assign m_pprot   = s_pprot;
    assign m_pwdata  = s_pwdata;
    assign m_pstrb   = s_pstrb;

    apb_split_resp #(.DATA_W(DATA_W), .NCH(NCH)) u_resp (
        .sel     (m_psel),
        .miss    (miss),
        .c_ready (m_pready),
        .c_err   (m_pslverr),
        .c_rdata (m_prdata),
        .ready   (s_pready),
        .err     (s_pslverr),
        .rdata   (s_prdata)
    );

    apb_split_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (s_psel),
        .penable   (s_penable),
        .pready    (s_pready),
        .in_access (in_access),
        .in_wait   (in_wait)
    );

    AST_ONE_CHILD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_psel)); // R1

    AST_WR_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_pwrite & ~m_psel) == '0); // R2

    for (genvar k = 2; k < NCH; k++) begin : g_arr_chk
        AST_ARR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            m_psel[k] |-> (m_paddr[k] < ADDR_W'(64'd1 << ARR_LOG2))); // R4
    end

    AST_ROUTE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_psel) |-> (s_pready == |(m_pready & m_psel))); // R6

    AST_MISS_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && miss) |-> (s_pready && s_pslverr && s_prdata == '0)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_psel |-> (m_psel == '0 && !s_pready && !s_pslverr)); // R8

    AST_WAIT_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && !s_pready) |=> (in_wait && m_psel == $past(m_psel))); // R9

endmodule

// File: tb/apb_split_bench.sv
module apb_split_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int NCH = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   s_psel = 1'b0, s_penable = 1'b0, s_pwrite = 1'b0;
    logic [AW-1:0]          s_paddr = '0;
    logic [2:0]             s_pprot = '0;
    logic [DW-1:0]          s_pwdata = '0;
    logic [3:0]             s_pstrb = '0;
    logic                   s_pready, s_pslverr;
    logic [DW-1:0]          s_prdata;
    logic [NCH-1:0]         m_psel, m_pwrite, m_pready, m_pslverr;
    logic                   m_penable;
    logic [NCH-1:0][AW-1:0] m_paddr;
    logic [NCH-1:0][DW-1:0] m_prdata;
    logic [2:0]             m_pprot;
    logic [DW-1:0]          m_pwdata;
    logic [3:0]             m_pstrb;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_split u_apb_split (
        .clk, .rst_n, .s_psel, .s_penable, .s_pwrite, .s_paddr, .s_pprot,
        .s_pwdata, .s_pstrb, .s_pready, .s_prdata, .s_pslverr,
        .m_psel, .m_penable, .m_pwrite, .m_paddr, .m_pprot, .m_pwdata,
        .m_pstrb, .m_pready, .m_prdata, .m_pslverr
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // behavioural children with random wait states
    int             wcnt[NCH];
    int             last_wait[NCH];
    logic           got_wr[NCH];
    logic [DW-1:0]  got_wdata[NCH];

    initial for (int i = 0; i < NCH; i++) begin
        wcnt[i] = 0; last_wait[i] = 0; got_wr[i] = 1'b0; got_wdata[i] = '0;
    end

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (m_psel[i] && !m_penable) begin
                wcnt[i]      <= int'($urandom_range(0, 3));
                last_wait[i] <= 0;
            end else if (m_psel[i] && m_penable) begin
                if (wcnt[i] != 0) begin
                    wcnt[i]      <= wcnt[i] - 1;
                    last_wait[i] <= last_wait[i] + 1;
                end else begin
                    got_wr[i]    <= m_pwrite[i];
                    got_wdata[i] <= m_pwdata;
                end
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_child
        assign m_pready[i]  = m_psel[i] & m_penable & (wcnt[i] == 0);
        assign m_prdata[i]  = {8'(i), 8'hA5, m_paddr[i]};
        assign m_pslverr[i] = m_pready[i] & (m_paddr[i][7:0] == 8'hEE);
    end

    // bench's own map
    function automatic int map_child(input logic [AW-1:0] a, output logic [AW-1:0] loc);
        loc = '0;
        if (a < 16'h1000) begin loc = a; return 0; end
        if (a < 16'h1400) begin loc = a - 16'h1000; return 1; end
        if (a >= 16'h2000 && a < 16'h2400) begin
            loc = (a - 16'h2000) % 16'h100;
            return 2 + int'((a - 16'h2000) / 16'h100);
        end
        return -1;
    endfunction

    typedef struct { logic [DW-1:0] rdata; logic err; } exp_t;
    exp_t sb[$];

    // monitor: compare each completed transfer
    always @(negedge clk) begin
        if (rst_n && s_psel && s_penable && s_pready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(s_prdata == e.rdata, "R6", "read data", s_prdata, e.rdata);
                chk(s_pslverr == e.err, "R6/R7", "error", s_pslverr, e.err);
            end
        end
    end

    task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd);
        logic [AW-1:0] loc;
        int   ch;
        int   waits;
        exp_t e;
        ch = map_child(a, loc);
        e.rdata = (ch < 0) ? '0 : {8'(ch), 8'hA5, loc};
        e.err   = (ch < 0) ? 1'b1 : (loc[7:0] == 8'hEE);
        sb.push_back(e);

        @(posedge clk); #1;
        s_psel = 1'b1; s_penable = 1'b0; s_pwrite = wr; s_paddr = a;
        s_pwdata = wd; s_pprot = a[2:0]; s_pstrb = wd[3:0];
        @(negedge clk);
        if (ch < 0) begin
            chk(m_psel == '0, "R7", "no child on miss", m_psel, 0);
        end else begin
            chk(m_psel == NCH'(1 << ch), "R1", "child select", m_psel, 1 << ch);
            chk(m_pwrite == (wr ? NCH'(1 << ch) : '0), "R2", "write strobe",
                m_pwrite, wr ? (1 << ch) : 0);
            chk(m_paddr[ch] == loc, (ch < 2) ? "R3" : "R4", "rebased address",
                m_paddr[ch], loc);
        end
        chk(m_pwdata == wd && m_pstrb == wd[3:0] && m_pprot == a[2:0] && !m_penable,
            "R5", "broadcast fields", m_pwdata, wd);

        @(posedge clk); #1;
        s_penable = 1'b1;
        waits = 0;
        forever begin
            @(negedge clk);
            if (waits == 0) begin
                chk(m_penable, "R5", "enable broadcast", m_penable, 1);
                if (ch < 0)
                    chk(s_pready, "R7", "miss ready first access cycle", s_pready, 1);
            end
            if (s_pready) break;
            chk(ch < 0 || m_psel == NCH'(1 << ch), "R9", "select held in wait",
                m_psel, (ch < 0) ? 0 : (1 << ch));
            waits++;
            if (waits > 20) break;
        end
        if (ch >= 0)
            chk(waits == last_wait[ch], "R9", "wait count", waits, last_wait[ch]);

        @(posedge clk); #1;
        s_psel = 1'b0; s_penable = 1'b0;
        @(negedge clk);
        chk(m_psel == '0 && !s_pready && !s_pslverr && s_prdata == '0, "R8",
            "idle bus quiet", {m_psel, s_pready, s_pslverr}, 0);
        if (ch >= 0 && wr)
            chk(got_wr[ch] && got_wdata[ch] == wd, "R2", "write reached child",
                got_wdata[ch], wd);
    endtask

    bit done = 0;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_psel == '0 && !s_pready && !s_pslverr && s_prdata == '0, "R8",
            "reset state", {m_psel, s_pready, s_pslverr}, 0);

        xfer(16'h0010, 1'b0, 32'h0);         // R1 R3 fixed child 0
        xfer(16'h0FFC, 1'b1, 32'hCAFE_0001); // R2 top of child 0
        xfer(16'h1000, 1'b0, 32'h0);         // R3 base of child 1
        xfer(16'h13EE, 1'b0, 32'h0);         // R6 child error routed
        xfer(16'h1400, 1'b0, 32'h0);         // R7 gap miss read
        xfer(16'h1FFF, 1'b1, 32'h1234_5678); // R7 gap miss write
        xfer(16'h2000, 1'b0, 32'h0);         // R4 array child 0
        xfer(16'h21EE, 1'b0, 32'h0);         // R4 array child 1 with error
        xfer(16'h23FF, 1'b0, 32'h0);         // R4 last array byte
        xfer(16'h2304, 1'b1, 32'hBEEF_0304); // R4 write to last array child
        xfer(16'h2400, 1'b0, 32'h0);         // R7 just past the array
        xfer(16'hFFFC, 1'b1, 32'h0BAD_F00D); // R7 top of space
        for (int n = 0; n < 40; n++)
            xfer(16'($urandom_range(0, 16'h27FF)), 1'($urandom_range(0, 1)), $urandom());

        chk(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
        done = 1;
        report();
    end

endmodule